// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits behind the write port of a parallel NOR-style flash device and interprets the stream of bus writes as commands. It recognises the two fixed unlock writes that precede every command. It recognises a program sequence, which is three command writes followed by one address/data write. It also recognises a six-write chip-erase sequence. Any write that breaks a sequence drops the controller back to read mode. Embedded program and erase work is represented by parameterised cycle counters rather than cell behaviour.

A running program can be suspended and resumed with single writes whose address is ignored. After a suspend command the controller needs a parameterised settling time before it reports the suspended state. While suspended, reads that target the sector being programmed are refused and reads of any other sector are allowed. While an operation runs, reads return a polling word: bit 7 is the inverse of the final data's bit 7, bit 6 toggles on every read, and bit 2 toggles on every read during an erase only.

Top module: `flash_cmd_seq`

## Requirements
- R1: Six writes form a chip erase, compared on address bits [10:0]: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h. The cycle after the sixth write, `mode` is 9 (erase) and `busy` is 1.
- R2: Once started, an erase keeps `busy` high for exactly ERASE_CYC cycles. It then returns to read mode, `mode` 0.
- R3: A write that differs from the next expected cycle of an unlock, program or erase sequence returns `mode` to 0 and starts no operation.
- R4: The writes 555h/AAh, 2AAh/55h, 555h/A0h followed by any address/data write start a program, `mode` 8. The program stays in `mode` 8 for exactly PGM_CYC cycles in total, not counting time spent suspended.
- R5: A read taken while `busy` returns a polling word one cycle later. Its bit 7 is the inverse of bit 7 of the final data (erase final data is FFh). Bits 5, 4, 3, 1 and 0 are 0. A read while not busy returns 00h.
- R6: The polling bits 6 and 2 both read 0 on the first read after an operation starts. Bit 6 inverts on each later busy read. Bit 2 inverts on each read during an erase and stays 0 during a program.
- R7: Writing B0h at any address during a program enters the settling state (`mode` 10) for exactly SUSP_CYC cycles, then the suspended state (`mode` 11, `busy` 0). The program time stays frozen.
- R8: Writing 30h at any address while suspended returns to programming (`mode` 8) on the next cycle. The program continues with its remaining time.
- R9: Writing 30h while already programming is ignored: the mode stays 8 and the completion time does not change.
- R10: A new suspend is accepted after a resume and behaves exactly as the first one.
- R11: `rd_ok` follows each read one cycle later. It is 0 while busy, 0 when suspended and the read sector equals the program's sector (address bits above SECT_LSB), and 1 otherwise.
- R12: In read mode, writes of B0h or 30h are ignored and the mode stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_sect | input | ADDR_W-SECT_LSB | Sector field of the read address |
| busy | output | 1 | An embedded operation or suspend settling is running |
| mode | output | 4 | Controller state code |
| poll | output | 8 | Polling word of the last read |
| rd_ok | output | 1 | Last read may be served from the array |

## Verification
A write sampled at a clock edge changes `mode` and `busy` after that same edge. The bench therefore drives at the falling edge and reads the result at the next falling edge. `poll` and `rd_ok` are registered from the read strobe, so they are read one falling edge after the read is issued. Operation lengths are measured by counting the falling-edge samples that show the state. Erase gives exactly ERASE_CYC samples and the settling state exactly SUSP_CYC samples. A free-running monitor counts program-state samples across suspends, and that total must equal PGM_CYC.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [3:0] {
    M_READ   = 4'd0,
    M_UNLK1  = 4'd1,
    M_UNLK2  = 4'd2,
    M_ESETUP = 4'd3,
    M_EUNLK1 = 4'd4,
    M_EUNLK2 = 4'd5,
    M_PADDR  = 4'd6,
    M_PROG   = 4'd8,
    M_ERASE  = 4'd9,
    M_SWAIT  = 4'd10,
    M_SUSP   = 4'd11
  } fcs_mode_e;

  localparam logic [10:0] A_FIRST  = 11'h555;
  localparam logic [10:0] A_SECOND = 11'h2AA;
  localparam logic [7:0]  D_FIRST  = 8'hAA;
  localparam logic [7:0]  D_SECOND = 8'h55;
  localparam logic [7:0]  D_ESETUP = 8'h80;
  localparam logic [7:0]  D_CHIP   = 8'h10;
  localparam logic [7:0]  D_PGM    = 8'hA0;
  localparam logic [7:0]  D_SUSP   = 8'hB0;
  localparam logic [7:0]  D_RESUME = 8'h30;

  function automatic logic cyc_is(input logic [10:0] a, input logic [7:0] d,
                                  input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic mode_busy(input fcs_mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_SWAIT);
  endfunction

  function automatic logic [7:0] poll_word(input logic inv7, input logic t6, input logic t2);
    return {inv7, t6, 3'b000, t2, 2'b00};
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import fcs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SECT_LSB = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       op_done,
  input  logic                       susp_done,
  output fcs_mode_e                  mode_q,
  output logic                       start_pgm,
  output logic                       start_erase,
  output logic                       start_susp,
  output logic                       pgm_msb_q,
  output logic [ADDR_W-SECT_LSB-1:0] pgm_sect_q
);
  fcs_mode_e   mode_d;
  logic [10:0] a11;

  assign a11 = wr_addr[10:0];

  always_comb begin
    mode_d      = mode_q;
    start_pgm   = 1'b0;
    start_erase = 1'b0;
    start_susp  = 1'b0;
    case (mode_q)
      M_READ:   if (wr_en && cyc_is(a11, wr_data, A_FIRST, D_FIRST)) mode_d = M_UNLK1;
      M_UNLK1:  if (wr_en) mode_d = cyc_is(a11, wr_data, A_SECOND, D_SECOND) ? M_UNLK2 : M_READ;
      M_UNLK2: begin
        if (wr_en) begin
          if (cyc_is(a11, wr_data, A_FIRST, D_PGM))         mode_d = M_PADDR;
          else if (cyc_is(a11, wr_data, A_FIRST, D_ESETUP)) mode_d = M_ESETUP;
          else                                              mode_d = M_READ;
        end
      end
      M_ESETUP: if (wr_en) mode_d = cyc_is(a11, wr_data, A_FIRST, D_FIRST) ? M_EUNLK1 : M_READ;
      M_EUNLK1: if (wr_en) mode_d = cyc_is(a11, wr_data, A_SECOND, D_SECOND) ? M_EUNLK2 : M_READ;
      M_EUNLK2: begin
        if (wr_en) begin
          if (cyc_is(a11, wr_data, A_FIRST, D_CHIP)) begin
            mode_d      = M_ERASE;
            start_erase = 1'b1;
          end else begin
            mode_d = M_READ;
          end
        end
      end
      M_PADDR: begin
        if (wr_en) begin
          mode_d    = M_PROG;
          start_pgm = 1'b1;
        end
      end
      M_PROG: begin
        if (op_done) mode_d = M_READ;
        else if (wr_en && wr_data == D_SUSP) begin
          mode_d     = M_SWAIT;
          start_susp = 1'b1;
        end
      end
      M_ERASE:  if (op_done) mode_d = M_READ;
      M_SWAIT:  if (susp_done) mode_d = M_SUSP;
      M_SUSP:   if (wr_en && wr_data == D_RESUME) mode_d = M_PROG;
      default:  mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_READ;
      pgm_msb_q  <= 1'b0;
      pgm_sect_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (start_pgm) begin
        pgm_msb_q  <= wr_data[7];
        pgm_sect_q <= wr_addr[ADDR_W-1:SECT_LSB];
      end
    end
  end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer
  import fcs_pkg::*;
#(
  parameter int PGM_CYC   = 400,
  parameter int ERASE_CYC = 2000,
  parameter int SUSP_CYC  = 1500
) (
  input  logic      clk,
  input  logic      rst_n,
  input  fcs_mode_e mode,
  input  logic      start_pgm,
  input  logic      start_erase,
  input  logic      start_susp,
  output logic      op_done,
  output logic      susp_done
);
  localparam int CW = $clog2(max3(PGM_CYC, ERASE_CYC, SUSP_CYC) + 1);

  logic [CW-1:0] op_cnt;
  logic [CW-1:0] sus_cnt;
  logic          running;

  assign running   = (mode == M_PROG) || (mode == M_ERASE);
  assign op_done   = running && (op_cnt == '0);
  assign susp_done = (mode == M_SWAIT) && (sus_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_cnt  <= '0;
      sus_cnt <= '0;
    end else begin
      if (start_pgm)                       op_cnt <= CW'(PGM_CYC - 1);
      else if (start_erase)                op_cnt <= CW'(ERASE_CYC - 1);
      else if (running && op_cnt != '0)    op_cnt <= op_cnt - 1'b1;

      if (start_susp)                              sus_cnt <= CW'(SUSP_CYC - 1);
      else if (mode == M_SWAIT && sus_cnt != '0)   sus_cnt <= sus_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import fcs_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcs_mode_e         mode,
  input  logic              start_op,
  input  logic              rd_en,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic              pgm_msb,
  input  logic [SECT_W-1:0] pgm_sect,
  output logic [7:0]        poll_q,
  output logic              rd_ok_q
);
  logic t6_q, t2_q, busy_now, inv7;

  assign busy_now = mode_busy(mode);
  assign inv7     = (mode == M_ERASE) ? 1'b0 : ~pgm_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q  <= 8'h00;
      rd_ok_q <= 1'b1;
      t6_q    <= 1'b0;
      t2_q    <= 1'b0;
    end else if (start_op) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (rd_en) begin
      if (busy_now) begin
        poll_q  <= poll_word(inv7, t6_q, t2_q);
        rd_ok_q <= 1'b0;
        t6_q    <= ~t6_q;
        if (mode == M_ERASE) t2_q <= ~t2_q;
      end else begin
        poll_q  <= 8'h00;
        rd_ok_q <= !((mode == M_SUSP) && (rd_sect == pgm_sect));
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_LSB  = 11,
  parameter int PGM_CYC   = 400,
  parameter int ERASE_CYC = 2000,
  parameter int SUSP_CYC  = 1500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-SECT_LSB-1:0] rd_sect,
  output logic                       busy,
  output logic [3:0]                 mode,
  output logic [7:0]                 poll,
  output logic                       rd_ok
);
  localparam int SECT_W = ADDR_W - SECT_LSB;

  fcs_mode_e         mode_q;
  logic              start_pgm, start_erase, start_susp;
  logic              op_done, susp_done;
  logic              pgm_msb;
  logic [SECT_W-1:0] pgm_sect;

  fcs_decoder #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done), .susp_done(susp_done), .mode_q(mode_q),
    .start_pgm(start_pgm), .start_erase(start_erase), .start_susp(start_susp),
    .pgm_msb_q(pgm_msb), .pgm_sect_q(pgm_sect)
  );

  fcs_timer #(.PGM_CYC(PGM_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_CYC(SUSP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .start_pgm(start_pgm),
    .start_erase(start_erase), .start_susp(start_susp),
    .op_done(op_done), .susp_done(susp_done)
  );

  fcs_status #(.SECT_W(SECT_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .start_op(start_pgm | start_erase),
    .rd_en(rd_en), .rd_sect(rd_sect), .pgm_msb(pgm_msb), .pgm_sect(pgm_sect),
    .poll_q(poll), .rd_ok_q(rd_ok)
  );

  assign busy = mode_busy(mode_q);
  assign mode = mode_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int SUSP_CYC = 1500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [3:0] mode,
  input logic       busy,
  input logic [7:0] poll,
  input logic       rd_ok
);
  int unsigned sw_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sw_cnt <= 0;
    else if (mode == M_SWAIT)  sw_cnt <= sw_cnt + 1;
    else                       sw_cnt <= 0;
  end

  // R3
  read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_READ |=> (mode == M_READ || mode == M_UNLK1));
  // R1
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_EUNLK2 && wr_en) |=> (mode == M_ERASE || mode == M_READ));
  // R2
  erase_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_ERASE |=> (mode == M_ERASE || mode == M_READ));
  // R7
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_SWAIT |-> sw_cnt < SUSP_CYC);
  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSP && !(wr_en && wr_data == D_RESUME)) |=> mode == M_SUSP);
  // R8
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSP && wr_en && wr_data == D_RESUME) |=> mode == M_PROG);
  // R9
  dup_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && wr_en && wr_data == D_RESUME) |=> (mode == M_PROG || mode == M_READ));
  // R12
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && wr_en && (wr_data == D_SUSP || wr_data == D_RESUME)) |=> mode == M_READ);
  // R11
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> !rd_ok);
  // R6
  pgm_no_dq2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == M_PROG) |=> !poll[2]);
  // R5
  idle_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> poll == 8'h00);
endmodule

bind flash_cmd_seq fcs_checker #(.SUSP_CYC(SUSP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .mode(mode), .busy(busy), .poll(poll), .rd_ok(rd_ok)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 16;
  localparam int SL = 11;
  localparam int PGM = 60;
  localparam int ERS = 80;
  localparam int SUS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [AW-SL-1:0] rd_sect = '0;
  logic busy, rd_ok;
  logic [3:0] mode;
  logic [7:0] poll;

  int n_run = 0;
  int n_fail = 0;
  int prog_n = 0;

  always #5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .SECT_LSB(SL), .PGM_CYC(PGM), .ERASE_CYC(ERS), .SUSP_CYC(SUS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sect(rd_sect), .busy(busy), .mode(mode), .poll(poll), .rd_ok(rd_ok)
  );

  always @(negedge clk) if (mode == 4'd8) prog_n++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-SL-1:0] s, output logic [7:0] p, output logic ok);
    @(negedge clk);
    rd_en = 1'b1; rd_sect = s;
    @(negedge clk);
    rd_en = 1'b0;
    p = poll; ok = rd_ok;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_erase();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h10);
  endtask

  task automatic start_prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(a, d);
  endtask

  task automatic wait_read_mode();
    for (int i = 0; i < 5000 && mode != 4'd0; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(mode == 4'd0, "R3 reset mode", mode, 0);
    chk(busy == 1'b0, "R2 reset busy", busy, 0);
    chk(poll == 8'h00, "R5 reset poll", poll, 0);
  endtask

  task automatic t_erase_len();
    int n;
    start_erase();
    chk(mode == 4'd9 && busy, "R1 erase entered", mode, 9);
    n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
    chk(n == ERS, "R2 erase busy length", n, ERS);
    chk(mode == 4'd0, "R2 back to read", mode, 0);
  endtask

  task automatic t_erase_poll();
    logic [7:0] p; logic ok;
    start_erase();
    rd(5'd1, p, ok); chk(p == 8'h00, "R6 erase poll 1", p, 8'h00);
    chk(ok == 1'b0, "R11 busy read refused", ok, 0);
    rd(5'd1, p, ok); chk(p == 8'h44, "R6 erase poll 2", p, 8'h44);
    rd(5'd1, p, ok); chk(p == 8'h00, "R5 erase poll 3", p, 8'h00);
    wait_read_mode();
    rd(5'd1, p, ok);
    chk(p == 8'h00, "R5 idle poll", p, 0);
    chk(ok == 1'b1, "R11 idle read allowed", ok, 1);
  endtask

  task automatic t_prog();
    logic [7:0] p; logic ok; int base;
    base = prog_n;
    start_prog(16'h1234, 8'h5A);
    chk(mode == 4'd8 && busy, "R4 program entered", mode, 8);
    rd(5'd2, p, ok); chk(p == 8'h80, "R5 program poll 1", p, 8'h80);
    rd(5'd2, p, ok); chk(p == 8'hC0, "R6 program poll 2", p, 8'hC0);
    rd(5'd2, p, ok); chk(p == 8'h80, "R6 program poll 3", p, 8'h80);
    wait_read_mode();
    chk(prog_n - base == PGM, "R4 program length", prog_n - base, PGM);
  endtask

  task automatic t_abort();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h54);
    chk(mode == 4'd0, "R3 bad second data", mode, 0);
    wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55);
    chk(mode == 4'd0, "R3 bad second address", mode, 0);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h30);
    chk(mode == 4'd0, "R3 bad erase confirm", mode, 0);
    idle(5);
    chk(busy == 1'b0, "R3 no operation started", busy, 0);
  endtask

  task automatic t_idle_cmds();
    wr(16'h0000, 8'hB0);
    chk(mode == 4'd0, "R12 suspend in read mode", mode, 0);
    wr(16'h0000, 8'h30);
    chk(mode == 4'd0 && !busy, "R12 resume in read mode", mode, 0);
  endtask

  task automatic t_suspend();
    logic [7:0] p; logic ok; int base, snap, n;
    base = prog_n;
    start_prog({5'd3, 11'h123}, 8'hA5);
    idle(5);
    wr(16'hFFFF, 8'hB0);
    chk(mode == 4'd10 && busy, "R7 settling entered", mode, 10);
    n = 0;
    while (mode == 4'd10 && n < 10000) begin n++; @(negedge clk); end
    chk(n == SUS, "R7 settling length", n, SUS);
    chk(mode == 4'd11 && !busy, "R7 suspended", mode, 11);
    snap = prog_n;
    idle(20);
    chk(prog_n == snap && mode == 4'd11, "R7 program frozen", prog_n - snap, 0);
    rd(5'd3, p, ok); chk(ok == 1'b0, "R11 same sector refused", ok, 0);
    rd(5'd5, p, ok); chk(ok == 1'b1, "R11 other sector allowed", ok, 1);
    wr(16'h4321, 8'h30);
    chk(mode == 4'd8, "R8 resumed", mode, 8);
    wr(16'h0777, 8'h30);
    chk(mode == 4'd8, "R9 duplicate resume ignored", mode, 8);
    idle(3);
    wr(16'h0001, 8'hB0);
    chk(mode == 4'd10, "R10 second suspend", mode, 10);
    n = 0;
    while (mode == 4'd10 && n < 10000) begin n++; @(negedge clk); end
    chk(n == SUS && mode == 4'd11, "R10 second settle", n, SUS);
    wr(16'h0000, 8'h30);
    wait_read_mode();
    chk(prog_n - base == PGM, "R8 total program time", prog_n - base, PGM);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_erase_len();
    t_erase_poll();
    t_prog();
    t_abort();
    t_idle_cmds();
    t_suspend();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule